// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is the device-side walker for a transmit descriptor ring kept in host memory. Software builds 16-byte descriptors, gives them to the device by setting an ownership flag, and writes a poll register. The engine then fetches descriptors one after another through a simple memory read/write port. For each descriptor it owns, it hands a frame request, made of a buffer address and a length, to the transmitter that follows it. When the transmitter reports completion, the engine gives the descriptor back to the host by clearing the ownership flag in memory.

The ring has no fixed length. A descriptor that carries the end-of-ring flag sends the next fetch back to the ring base. The engine stops at the first descriptor still held by the host. Single-cycle event pulses report a good transmission, a malformed descriptor and a stop on a host-owned entry. There is one normal-priority queue. Frame data movement, framing and offloads are handled elsewhere.

Top module: `tx_ring_engine`

## Requirements
- R1: Descriptor n sits at ring base + 16*n. Its words are control at byte offset 0, an unused tag word at offset 4, buffer address low at offset 8 and buffer address high at offset 12. The engine never reads the word at offset 4, and it reads the two address words only for a descriptor that will be sent.
- R2: Control word fields: bit 31 ownership (1 = device), bit 30 end of ring, bit 29 first segment, bit 28 last segment, bits 15:0 frame length in bytes.
- R3: A register write to address 2 with bit 6 set starts a pass over the ring. A write to address 2 with bit 6 clear starts nothing.
- R4: When a fetched control word has bit 31 clear, the engine presents no frame for it, writes nothing back, pulses tx_unavail_o for one cycle and goes idle.
- R5: For an owned descriptor with bits 29 and 28 both set, frm_addr_o = {high word, low word} and frm_len_o = control[15:0]. Both are held with frm_valid_o until frm_ready_i.
- R6: After frm_done_i, the engine writes the control word back to its own address with only bit 31 cleared (end-of-ring and all other bits kept). tx_ok_o then pulses for one cycle in the cycle after that write is granted.
- R7: An owned descriptor without both bits 29 and 28 set produces no frame request. It is written back with bit 31 cleared, and tx_err_o pulses once.
- R8: The fetch after a descriptor with bit 30 set is made at the ring base.
- R9: The ring base is written as a low word (register address 0) and a high word (register address 1). Bits 7:0 of the low word are ignored, so the base is aligned to 256 bytes.
- R10: The ring index is zero after reset and after any write to either base register, so the next fetch is made at the base.
- R11: A poll written while a pass is in progress is remembered. After the current pass stops, the engine makes one more pass starting at the descriptor where it stopped.
- R12: A memory request holds its address, direction and write data unchanged until mem_gnt_i. Read data is taken in the cycle of the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 base low, 1 base high, 2 poll |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 64 | Byte address of the 32-bit word |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Access completes this cycle |
| mem_rdata_i | input | 32 | Read data, valid with the grant |
| frm_valid_o | output | 1 | Frame request valid |
| frm_addr_o | output | 64 | Frame buffer address |
| frm_len_o | output | 16 | Frame length |
| frm_ready_i | input | 1 | Frame request accepted |
| frm_done_i | input | 1 | Accepted frame finished |
| tx_ok_o | output | 1 | Frame completed and returned |
| tx_err_o | output | 1 | Malformed descriptor skipped |
| tx_unavail_o | output | 1 | Stopped on host-owned descriptor |

## Verification
The assertions check on every cycle that memory requests and frame requests stay stable until they are accepted, that at most one event pulse fires at a time, and that every good-frame pulse follows a granted write-back. They also check that a poll write is latched and that rewriting the base or wrapping the ring points the next fetch at the base. The exact order of fetch addresses is shown only by the bench scenarios compared against its behavioural ring model. The same holds for the write-back contents, the frame address and length, the pass repeated after a poll arrives mid-pass, and the index reset caused by a base rewrite. These scenarios run with both an always-granting memory and a stalling one.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int unsigned OWN_B   = 31;
  localparam int unsigned EOR_B   = 30;
  localparam int unsigned FS_B    = 29;
  localparam int unsigned LS_B    = 28;
  localparam int unsigned LEN_W   = 16;
  localparam int unsigned POLL_B  = 6;
  localparam int unsigned DESC_LG = 4;   // 16-byte descriptors
  localparam int unsigned OFF_LO  = 8;
  localparam int unsigned OFF_HI  = 12;

  localparam logic [1:0] RA_BASE_LO = 2'd0;
  localparam logic [1:0] RA_BASE_HI = 2'd1;
  localparam logic [1:0] RA_POLL    = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_CTRL, S_LO, S_HI, S_SEND, S_WAIT, S_WB
  } txr_st_e;
endpackage

// File: rtl/txr_regs.sv
module txr_regs
  import txr_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned ALIGN_W = 8,
  localparam int unsigned AW     = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          start_i,
  output logic [AW-1:0] base_o,
  output logic          base_wr_o,
  output logic          poll_pend_o
);
  logic [DW-1:ALIGN_W] lo_q;
  logic [DW-1:0]       hi_q;
  logic                pend_q;

  logic wr_lo, wr_hi, poll_hit;
  assign wr_lo    = we_i && (addr_i == RA_BASE_LO);
  assign wr_hi    = we_i && (addr_i == RA_BASE_HI);
  assign poll_hit = we_i && (addr_i == RA_POLL) && wdata_i[POLL_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      if (wr_lo) lo_q <= wdata_i[DW-1:ALIGN_W];
      if (wr_hi) hi_q <= wdata_i;
      // a new poll wins over the clear from a starting pass
      if (poll_hit)     pend_q <= 1'b1;
      else if (start_i) pend_q <= 1'b0;
    end
  end

  assign base_o      = {hi_q, lo_q, {ALIGN_W{1'b0}}};
  assign base_wr_o   = wr_lo | wr_hi;
  assign poll_pend_o = pend_q;

  p_poll_latch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_hit |=> poll_pend_o);
endmodule

// File: rtl/txr_ptr.sv
module txr_ptr
  import txr_pkg::*;
#(
  parameter int unsigned AW    = 64,
  parameter int unsigned IDX_W = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] desc_addr_o
);
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (clear_i) idx_q <= '0;
    else if (adv_i)   idx_q <= wrap_i ? '0 : idx_q + 1'b1;
  end

  assign desc_addr_o = base_i + AW'({idx_q, {DESC_LG{1'b0}}});

  p_rebase_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> desc_addr_o == base_i);
  p_wrap_base_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && wrap_i && !clear_i) |=> desc_addr_o == base_i);
endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
#(
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             poll_pend_i,
  input  logic [AW-1:0]    desc_addr_i,
  output logic             start_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             frm_valid_o,
  output logic [AW-1:0]    frm_addr_o,
  output logic [LEN_W-1:0] frm_len_o,
  input  logic             frm_ready_i,
  input  logic             frm_done_i,
  output logic             tok_o,
  output logic             ter_o,
  output logic             tdu_o
);
  localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_B;

  txr_st_e       st_q;
  logic [DW-1:0] ctrl_q, lo_q, hi_q;
  logic          good_q, tok_q, ter_q, tdu_q;
  logic [DESC_LG-1:0] off;

  always_comb begin
    case (st_q)
      S_LO:    off = DESC_LG'(OFF_LO);
      S_HI:    off = DESC_LG'(OFF_HI);
      default: off = '0;
    endcase
  end

  assign start_o     = (st_q == S_IDLE) && poll_pend_i;
  assign mem_req_o   = (st_q == S_CTRL) || (st_q == S_LO) || (st_q == S_HI) || (st_q == S_WB);
  assign mem_we_o    = (st_q == S_WB);
  assign mem_addr_o  = desc_addr_i + AW'(off);
  assign mem_wdata_o = ctrl_q & ~OWN_MASK;
  assign adv_o       = (st_q == S_WB) && mem_gnt_i;
  assign wrap_o      = ctrl_q[EOR_B];
  assign frm_valid_o = (st_q == S_SEND);
  assign frm_addr_o  = {hi_q, lo_q};
  assign frm_len_o   = ctrl_q[LEN_W-1:0];
  assign tok_o       = tok_q;
  assign ter_o       = ter_q;
  assign tdu_o       = tdu_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      ctrl_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      good_q <= 1'b0;
      tok_q  <= 1'b0;
      ter_q  <= 1'b0;
      tdu_q  <= 1'b0;
    end else begin
      tok_q <= 1'b0;
      ter_q <= 1'b0;
      tdu_q <= 1'b0;
      case (st_q)
        S_IDLE: if (poll_pend_i) st_q <= S_CTRL;
        S_CTRL: if (mem_gnt_i) begin
          ctrl_q <= mem_rdata_i;
          if (!mem_rdata_i[OWN_B]) begin
            tdu_q <= 1'b1;
            st_q  <= S_IDLE;
          end else if (mem_rdata_i[FS_B] && mem_rdata_i[LS_B]) begin
            good_q <= 1'b1;
            st_q   <= S_LO;
          end else begin
            good_q <= 1'b0;
            st_q   <= S_WB;
          end
        end
        S_LO: if (mem_gnt_i) begin
          lo_q <= mem_rdata_i;
          st_q <= S_HI;
        end
        S_HI: if (mem_gnt_i) begin
          hi_q <= mem_rdata_i;
          st_q <= S_SEND;
        end
        S_SEND: if (frm_ready_i) st_q <= S_WAIT;
        S_WAIT: if (frm_done_i)  st_q <= S_WB;
        S_WB: if (mem_gnt_i) begin
          tok_q <= good_q;
          ter_q <= !good_q;
          st_q  <= S_CTRL;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> mem_req_o && $stable(mem_addr_o)
                                  && $stable(mem_we_o) && $stable(mem_wdata_o));
  p_frm_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_valid_o && !frm_ready_i) |=> frm_valid_o && $stable(frm_addr_o)
                                      && $stable(frm_len_o));
  p_evt_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tok_o, ter_o, tdu_o}));
  p_tok_after_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |-> $past(mem_req_o && mem_we_o && mem_gnt_i));
  p_tdu_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tdu_o |-> !frm_valid_o && !mem_we_o);
endmodule

// File: rtl/tx_ring_engine.sv
module tx_ring_engine
  import txr_pkg::*;
#(
  parameter int unsigned DW      = 32,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned ALIGN_W = 8,
  localparam int unsigned AW     = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             frm_valid_o,
  output logic [AW-1:0]    frm_addr_o,
  output logic [LEN_W-1:0] frm_len_o,
  input  logic             frm_ready_i,
  input  logic             frm_done_i,
  output logic             tx_ok_o,
  output logic             tx_err_o,
  output logic             tx_unavail_o
);
  logic [AW-1:0] base, desc_addr;
  logic          base_wr, poll_pend, start, adv, wrap;

  txr_regs #(.DW(DW), .ALIGN_W(ALIGN_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .start_i    (start),
    .base_o     (base),
    .base_wr_o  (base_wr),
    .poll_pend_o(poll_pend)
  );

  txr_ptr #(.AW(AW), .IDX_W(IDX_W)) u_ptr (
    .clk_i, .rst_ni,
    .clear_i    (base_wr),
    .adv_i      (adv),
    .wrap_i     (wrap),
    .base_i     (base),
    .desc_addr_o(desc_addr)
  );

  txr_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni,
    .poll_pend_i(poll_pend),
    .desc_addr_i(desc_addr),
    .start_o    (start),
    .adv_o      (adv),
    .wrap_o     (wrap),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_gnt_i, .mem_rdata_i,
    .frm_valid_o, .frm_addr_o, .frm_len_o,
    .frm_ready_i, .frm_done_i,
    .tok_o      (tx_ok_o),
    .ter_o      (tx_err_o),
    .tdu_o      (tx_unavail_o)
  );
endmodule

// File: tb/tb_tx_ring_engine.sv
`timescale 1ns/1ps
module tb_tx_ring_engine;
  localparam logic [31:0] OWN = 32'h8000_0000, EOR = 32'h4000_0000;
  localparam logic [31:0] FS  = 32'h2000_0000, LS  = 32'h1000_0000;
  localparam byte EV_T = 8'h54, EV_E = 8'h45, EV_U = 8'h55;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [63:0] mem_addr_o;
  logic [31:0] mem_wdata_o;
  logic        mem_gnt_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        frm_valid_o;
  logic [63:0] frm_addr_o;
  logic [15:0] frm_len_o;
  logic        frm_ready_i = 1'b0, frm_done_i = 1'b0;
  logic        tx_ok_o, tx_err_o, tx_unavail_o;

  tx_ring_engine dut (.clk_i(clk), .*);

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R10";
  bit stall_en = 1'b0, waiting = 1'b0;
  int rdy_dly = 0, done_dly = 2, rdy_cnt = 0, done_cnt = 0;

  logic [31:0] bmem [logic [63:0]];
  logic [31:0] rmem [logic [63:0]];
  logic [63:0] exp_rd[$], exp_wa[$], exp_fa[$];
  logic [31:0] exp_wd[$];
  logic [15:0] exp_fl[$];
  byte         exp_ev[$];
  logic [63:0] mbase = '0;
  int          midx = 0;

  function automatic logic [31:0] brd(logic [63:0] a);
    return bmem.exists(a) ? bmem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rrd(logic [63:0] a);
    return rmem.exists(a) ? rmem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  task automatic ev_seen(input byte e);
    if (exp_ev.size() == 0) chk(1'b0, "unexpected event", 64'(e), 64'h0);
    else begin
      byte x;
      x = exp_ev.pop_front();
      chk(x == e, "event", 64'(e), 64'(x));
    end
  endtask

  // memory, frame sink and event monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL %s watchdog actual=timeout expected=completion", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (!rst_ni) begin
      mem_gnt_i = 1'b0; frm_ready_i = 1'b0; frm_done_i = 1'b0;
    end else begin
      if (tx_ok_o)      ev_seen(EV_T);
      if (tx_err_o)     ev_seen(EV_E);
      if (tx_unavail_o) ev_seen(EV_U);
      mem_gnt_i = mem_req_o && (!stall_en || (cyc % 3) != 0);
      if (mem_gnt_i) begin
        if (mem_we_o) begin
          if (exp_wa.size() == 0) chk(1'b0, "unexpected write", mem_addr_o, 64'h0);
          else begin
            logic [63:0] a; logic [31:0] d;
            a = exp_wa.pop_front(); d = exp_wd.pop_front();
            chk(mem_addr_o == a, "write addr", mem_addr_o, a);
            chk(mem_wdata_o == d, "write data", 64'(mem_wdata_o), 64'(d));
          end
          bmem[mem_addr_o] = mem_wdata_o;
        end else begin
          if (exp_rd.size() == 0) chk(1'b0, "unexpected read", mem_addr_o, 64'h0);
          else begin
            logic [63:0] a;
            a = exp_rd.pop_front();
            chk(mem_addr_o == a, "read addr", mem_addr_o, a);
          end
          mem_rdata_i = brd(mem_addr_o);
        end
      end
      if (frm_done_i) frm_done_i = 1'b0;
      if (frm_ready_i) begin
        frm_ready_i = 1'b0; done_cnt = done_dly; waiting = 1'b1;
      end else if (waiting) begin
        if (done_cnt == 0) begin frm_done_i = 1'b1; waiting = 1'b0; end
        else done_cnt--;
      end else if (frm_valid_o) begin
        if (rdy_cnt == 0) begin
          frm_ready_i = 1'b1; rdy_cnt = rdy_dly;
          if (exp_fa.size() == 0) chk(1'b0, "unexpected frame", frm_addr_o, 64'h0);
          else begin
            logic [63:0] fa; logic [15:0] fl;
            fa = exp_fa.pop_front(); fl = exp_fl.pop_front();
            chk(frm_addr_o == fa, "frame addr", frm_addr_o, fa);
            chk(frm_len_o == fl, "frame len", 64'(frm_len_o), 64'(fl));
          end
        end else rdy_cnt--;
      end
    end
  end

  // behavioural ring walk, one pass per poll
  task automatic model_pass();
    for (int n = 0; n < 4096; n++) begin
      logic [63:0] a; logic [31:0] c; bit good;
      a = mbase + 64'(midx) * 64'd16;
      c = rrd(a);
      exp_rd.push_back(a);
      if (!c[31]) begin exp_ev.push_back(EV_U); break; end
      good = c[29] && c[28];
      if (good) begin
        exp_rd.push_back(a + 64'd8);
        exp_rd.push_back(a + 64'd12);
        exp_fa.push_back({rrd(a + 64'd12), rrd(a + 64'd8)});
        exp_fl.push_back(c[15:0]);
      end
      exp_wa.push_back(a);
      exp_wd.push_back(c & ~OWN);
      rmem[a] = c & ~OWN;
      exp_ev.push_back(good ? EV_T : EV_E);
      midx = c[30] ? 0 : midx + 1;
    end
  endtask

  task automatic reg_write(input logic [1:0] ra, input logic [31:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = ra; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic set_base(input logic [31:0] lo, input logic [31:0] hi);
    reg_write(2'd0, lo);
    reg_write(2'd1, hi);
    mbase = {hi, lo[31:8], 8'h00};
    midx  = 0;
  endtask

  task automatic set_desc(input int i, input logic [31:0] c, input logic [63:0] b);
    logic [63:0] a;
    a = mbase + 64'(i) * 64'd16;
    bmem[a] = c;              rmem[a] = c;
    bmem[a + 4] = 32'hDEAD_0000 | 32'(i); rmem[a + 4] = bmem[a + 4];
    bmem[a + 8] = b[31:0];    rmem[a + 8] = b[31:0];
    bmem[a + 12] = b[63:32];  rmem[a + 12] = b[63:32];
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((exp_rd.size() + exp_wa.size() + exp_fa.size() + exp_ev.size()) != 0 && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, "drain", 64'(exp_rd.size() + exp_ev.size()), 64'h0);
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10: quiet after reset
    chk(!mem_req_o && !frm_valid_o, "R10 reset outputs", {mem_req_o, frm_valid_o}, 0);
    chk(!tx_ok_o && !tx_err_o && !tx_unavail_o, "R10 reset events",
        {tx_ok_o, tx_err_o, tx_unavail_o}, 0);

    // R1 R2 R5 R6 R4: two frames then stop
    cur_req = "R1 R2 R5 R6 R4";
    set_base(32'h2345_6700, 32'h0000_0001);
    set_desc(0, OWN | FS | LS | 32'h0005_0040, 64'hA000_0000_1000_0000);
    set_desc(1, OWN | FS | LS | 32'd1500,      64'h0000_0002_0000_0800);
    set_desc(2, FS | LS | 32'd10,              64'h1);
    model_pass();
    reg_write(2'd2, 32'h40);
    drain();

    // R3: poll with bit 6 clear does nothing
    cur_req = "R3";
    reg_write(2'd2, 32'hFFFF_FFBF);
    repeat (30) @(negedge clk);
    chk(!mem_req_o && !frm_valid_o, "R3 no start", {mem_req_o, frm_valid_o}, 0);

    // R11 R12: poll during a pass, stalled memory and slow sink
    cur_req = "R11 R12 R4";
    stall_en = 1'b1; rdy_dly = 3; done_dly = 40; rdy_cnt = 3;
    set_desc(2, OWN | FS | LS | 32'd256, 64'h0000_0003_4444_0000);
    set_desc(3, 32'h0, 64'h0);
    model_pass();
    model_pass();
    reg_write(2'd2, 32'h40);
    while (!frm_valid_o) @(negedge clk);
    reg_write(2'd2, 32'h40);
    drain();

    // R7 R2: malformed descriptors are skipped
    cur_req = "R7 R2";
    done_dly = 2;
    set_desc(3, OWN | FS | 32'd100, 64'h5);
    set_desc(4, OWN | LS | 32'd200, 64'h6);
    set_desc(5, OWN | FS | LS | 32'd300, 64'h0000_0000_7000_0000);
    set_desc(6, 32'h0, 64'h0);
    model_pass();
    reg_write(2'd2, 32'h40);
    drain();

    // R8 R6: end of ring wraps, flag kept on write-back
    cur_req = "R8 R6";
    stall_en = 1'b0;
    set_desc(6, OWN | EOR | FS | LS | 32'h0777, 64'h0000_0009_0000_1000);
    model_pass();
    reg_write(2'd2, 32'h40);
    drain();

    // R9 R10: base rewrite with low bits set resets the index
    cur_req = "R9 R10";
    set_desc(0, OWN | FS | LS | 32'h0011, 64'h0000_0000_0000_2000);
    model_pass();
    reg_write(2'd2, 32'h40);
    drain();
    set_base(32'h2345_67FF, 32'h0000_0001);
    set_desc(0, OWN | FS | LS | 32'h0012, 64'h0000_0000_0000_3000);
    model_pass();
    reg_write(2'd2, 32'h40);
    drain();

    // R8: one-entry ring at a new base
    cur_req = "R8 R9";
    set_base(32'h0000_8000, 32'h0);
    set_desc(0, OWN | EOR | FS | LS | 32'h0022, 64'h0000_0000_0000_4000);
    model_pass();
    reg_write(2'd2, 32'h40);
    drain();

    cur_req = "R1";
    chk(exp_rd.size() == 0 && exp_wa.size() == 0 && exp_fa.size() == 0,
        "leftover", 64'(exp_rd.size() + exp_wa.size() + exp_fa.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule